// File: doc/BRIEF.md
# Nibble-Bus Cell Receiver

This block takes fixed-length cells from a link partner over a four-bit synchronous bus. The bus carries a one-cycle frame marker and four data lines. The receiver drives the transfer clock itself. It divides the system clock, and the clock runs only while the partner reports that a cell is ready, or while a cell is still arriving. At other times the clock rests low.

A frame marker seen on a rising edge of the transfer clock opens a cell. The next 2*CELL_BYTES rising edges each carry one nibble. Pairs of nibbles are packed into bytes, with the high nibble first. Each byte is presented for one system clock cycle, and a flag marks the first byte of every cell. A marker that arrives while a cell is still open is reported as a framing error, and the receiver restarts the cell on that marker.

Top module: `nib_cell_rx`

## Requirements
- R1: While reset is asserted and on the first cycle after it, tx_clk, byte_valid, first_byte and frame_err are all 0.
- R2: When cell_avail is 0 and no cell is in progress, tx_clk stays low and has no rising edge.
- R3: While running, tx_clk is high for HALF system cycles and low for HALF system cycles, so it has a period of 2*HALF system cycles.
- R4: frame_in and nib_in are sampled only at rising edges of tx_clk. The first data nibble is sampled on the rising edge after the marker, and a whole cell takes 1 + 2*CELL_BYTES rising edges (107 at the default).
- R5: Each byte equals {first nibble, second nibble}. The nibble sampled first is bits 7:4.
- R6: Every byte is presented on byte_out with byte_valid high for exactly one system cycle, and each cell gives CELL_BYTES bytes. first_byte is 1 together with byte_valid on byte 0 of a cell and is 0 at all other times.
- R7: Once a cell has started, it completes even if cell_avail drops. After its last nibble, tx_clk returns low and stays low while cell_avail is 0.
- R8: A marker sampled while a cell is in progress produces a one-cycle pulse on frame_err. The bytes of the cut-short cell that were already emitted remain. The marker then opens a new cell, whose next nibble is the high half of byte 0.
- R9: Nibbles sampled while no cell is in progress are ignored and give no byte_valid.
- R10: Back-to-back cells, where a new marker comes on the edge after the previous cell's last nibble, are received without a framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, running at least twice the transfer rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_avail | input | 1 | Partner reports that a cell is ready to send |
| frame_in | input | 1 | Frame marker from the partner, high for one transfer cycle |
| nib_in | input | 4 | Data nibble from the partner |
| tx_clk | output | 1 | Gated transfer clock driven to the partner |
| byte_out | output | 8 | Assembled byte |
| byte_valid | output | 1 | byte_out holds a new byte (one system cycle) |
| first_byte | output | 1 | The current byte is byte 0 of its cell |
| frame_err | output | 1 | One-cycle pulse: marker arrived inside a cell |

## Verification
The bench builds the receiver with HALF = 2 and the default CELL_BYTES = 53. With HALF = 2 there are system cycles on which the transfer clock holds its level, so the bench can confirm that nothing is sampled between transfer edges and can measure both the high and low widths. Keeping full-length cells makes the 107-edge cell length, the mid-cell drop of cell_avail and the gap-free back-to-back case run at their real size, and with HALF = 2 each cell still needs only about 430 system cycles.

// File: rtl/nib_cell_rx.sv
module nib_cell_rx #(
  parameter int CELL_BYTES = 53,
  parameter int HALF       = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cell_avail,
  input  logic       frame_in,
  input  logic [3:0] nib_in,
  output logic       tx_clk,
  output logic [7:0] byte_out,
  output logic       byte_valid,
  output logic       first_byte,
  output logic       frame_err
);
  localparam int NIBS = 2 * CELL_BYTES;
  localparam int NW   = $clog2(NIBS);
  localparam int CW   = $clog2(HALF + 1);

  logic [CW-1:0] ph;
  logic [NW-1:0] nib_cnt;
  logic [3:0]    hi_nib;
  logic          busy;

  wire go     = cell_avail | busy;
  wire ph_end = (ph == CW'(HALF - 1));
  wire rise   = !tx_clk && go && ph_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_clk <= 1'b0;
      ph     <= '0;
    end else if (tx_clk || go) begin
      if (ph_end) begin
        ph     <= '0;
        tx_clk <= ~tx_clk;
      end else begin
        ph <= ph + CW'(1);
      end
    end else begin
      ph <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      nib_cnt    <= '0;
      hi_nib     <= '0;
      byte_out   <= '0;
      byte_valid <= 1'b0;
      first_byte <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      first_byte <= 1'b0;
      frame_err  <= 1'b0;
      if (rise) begin
        if (frame_in) begin
          frame_err <= busy;
          busy      <= 1'b1;
          nib_cnt   <= '0;
        end else if (busy) begin
          if (!nib_cnt[0]) begin
            hi_nib <= nib_in;
          end else begin
            byte_out   <= {hi_nib, nib_in};
            byte_valid <= 1'b1;
            first_byte <= (nib_cnt == NW'(1));
          end
          if (nib_cnt == NW'(NIBS - 1)) busy <= 1'b0;
          nib_cnt <= nib_cnt + NW'(1);
        end
      end
    end
  end

  a_r2_idle_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_clk && !cell_avail && !busy) |=> !tx_clk);

  a_r7_cell_not_paused: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_clk && ph_end) |=> tx_clk);

  a_r6_first_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    first_byte |-> byte_valid);

  a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  a_r8_err_inside_cell: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(busy));

  a_r4_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $rose(tx_clk));
endmodule

// File: tb/test_nib_cell_rx.sv
`timescale 1ns/1ps
module test_nib_cell_rx;
  localparam int HALF = 2;
  localparam int CELL = 53;

  logic clk = 1'b0;
  logic rst_n, cell_avail, frame_in;
  logic [3:0] nib_in;
  logic tx_clk, byte_valid, first_byte, frame_err;
  logic [7:0] byte_out;

  always #2.5 clk = ~clk;

  nib_cell_rx #(.CELL_BYTES(CELL), .HALF(HALF)) i_nib_cell_rx (
    .clk(clk), .rst_n(rst_n), .cell_avail(cell_avail), .frame_in(frame_in),
    .nib_in(nib_in), .tx_clk(tx_clk), .byte_out(byte_out),
    .byte_valid(byte_valid), .first_byte(first_byte), .frame_err(frame_err));

  logic [8:0] exp_q[$];
  int checks = 0, errors = 0;
  int rx_count = 0, err_pulses = 0, rise_cnt = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge tx_clk) rise_cnt++;

  always @(negedge clk) begin
    if (rst_n && frame_err) err_pulses++;
    if (rst_n && byte_valid) begin
      rx_count++;
      if (exp_q.size() == 0) begin
        check(0, "R9", "unexpected byte", int'(byte_out), -1);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check({first_byte, byte_out} == e, "R5/R6", "byte {first,data}",
              int'({first_byte, byte_out}), int'(e));
      end
    end
  end

  task automatic next_edge();
    @(posedge tx_clk);
    @(negedge clk);
  endtask

  task automatic send_cell(input int nbytes, input int seed, input int drop_at);
    frame_in = 1'b1; nib_in = 4'h0;
    next_edge();
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b;
      b = 8'((seed + i * 37) & 8'hFF);
      exp_q.push_back({(i == 0), b});
      frame_in = 1'b0; nib_in = b[7:4];
      next_edge();
      if (i == drop_at) cell_avail = 1'b0;
      nib_in = b[3:0];
      next_edge();
    end
    frame_in = 1'b0; nib_in = 4'h0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int highs, r0, b0, e0;
    time t0, t1, t2;
    rst_n = 1'b0; cell_avail = 1'b0; frame_in = 1'b0; nib_in = 4'h0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(tx_clk == 0 && byte_valid == 0 && first_byte == 0 && frame_err == 0,
          "R1", "outputs in reset", int'({tx_clk, byte_valid, first_byte, frame_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_clk == 0 && byte_valid == 0 && frame_err == 0,
          "R1", "outputs after reset", int'({tx_clk, byte_valid, frame_err}), 0);

    // R2: idle, no clock
    highs = 0;
    nib_in = 4'h9;
    repeat (30) begin @(negedge clk); if (tx_clk) highs++; end
    check(highs == 0 && rise_cnt == 0, "R2", "tx_clk high cycles while idle", highs, 0);

    // R9: clock runs, nibbles but no marker
    cell_avail = 1'b1;
    for (int k = 0; k < 20; k++) begin nib_in = 4'(k); next_edge(); end
    repeat (4) @(negedge clk);
    check(rx_count == 0, "R9", "bytes without marker", rx_count, 0);

    // R3: period and high width
    @(posedge tx_clk); t0 = $time;
    @(negedge tx_clk); t1 = $time;
    @(posedge tx_clk); t2 = $time;
    check((t1 - t0) == HALF * 5, "R3", "high width ns", int'(t1 - t0), HALF * 5);
    check((t2 - t0) == 2 * HALF * 5, "R3", "period ns", int'(t2 - t0), 2 * HALF * 5);
    @(negedge clk);

    // R4 R5 R6: full cell
    b0 = rx_count;
    send_cell(CELL, 3, -1);
    repeat (4) @(negedge clk);
    check(rx_count - b0 == CELL, "R6", "bytes per cell", rx_count - b0, CELL);
    check(exp_q.size() == 0, "R5", "expected bytes left", exp_q.size(), 0);

    // R7 and R4: partner drops cell_avail part way through
    cell_avail = 1'b0;
    repeat (4 * HALF + 4) @(negedge clk);
    check(tx_clk == 0, "R2", "clock parked low after drop", int'(tx_clk), 0);
    r0 = rise_cnt; b0 = rx_count;
    frame_in = 1'b1;
    cell_avail = 1'b1;
    send_cell(CELL, 100, 10);
    repeat (4 * HALF + 20) @(negedge clk);
    check(rise_cnt - r0 == 2 * CELL + 1, "R4", "rising edges per cell", rise_cnt - r0, 2 * CELL + 1);
    check(rx_count - b0 == CELL, "R7", "bytes after mid-cell drop", rx_count - b0, CELL);
    r0 = rise_cnt;
    repeat (30) @(negedge clk);
    check(rise_cnt == r0 && tx_clk == 0, "R7", "rises after cell end", rise_cnt - r0, 0);

    // R8: marker inside a cell
    cell_avail = 1'b1;
    b0 = rx_count; e0 = err_pulses;
    send_cell(5, 9, -1);
    send_cell(CELL, 200, -1);
    repeat (4) @(negedge clk);
    check(err_pulses - e0 == 1, "R8", "framing error pulses", err_pulses - e0, 1);
    check(rx_count - b0 == 5 + CELL, "R8", "bytes across resync", rx_count - b0, 5 + CELL);
    check(exp_q.size() == 0, "R8", "expected bytes left", exp_q.size(), 0);

    // R10: back-to-back cells
    b0 = rx_count; e0 = err_pulses;
    send_cell(CELL, 77, -1);
    send_cell(CELL, 150, -1);
    repeat (4) @(negedge clk);
    check(err_pulses == e0, "R10", "false framing errors", err_pulses - e0, 0);
    check(rx_count - b0 == 2 * CELL, "R10", "bytes from two cells", rx_count - b0, 2 * CELL);
    check(exp_q.size() == 0, "R10", "expected bytes left", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule